// File: doc/BRIEF.md
# Clock-Stop Wake-Up Sequencer

This block sits in the system integration logic of a small microcontroller and handles the clock-stopped low-power state. A stop command from the CPU, accepted while the system is running, turns off both gated clock enables: the one for the CPU and the one for the peripheral clock. The CPU and all peripherals halt while the enables are off. The oscillator clock that runs this block is never gated, so the block keeps running during stop.

An interrupt or break request wakes the block. It then waits out a recovery period timed by an internal counter on the oscillator clock. The counter is held at zero for the whole stopped interval and starts counting only when recovery begins. The wait is either long (4096 oscillator cycles) or short (32 cycles). A configuration bit picks one, and the block samples that bit at the moment stop is entered. When the count ends, both clock enables return and a one-cycle CPU-release strobe is given in the same cycle.

A break that wakes the block from stop also sets a sticky status flag, which software clears. Requests that arrive during recovery are ignored.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is running: `cpuClkEn` and `perClkEn` are 1, `cpuRelease` is 0 and `brkStopFlag` is 0.
- R2: A `stopReq` sampled high at a clock edge while running drives `cpuClkEn` and `perClkEn` to 0 from that edge on. Both stay 0 until recovery completes.
- R3: With `fastWakeCfg` = 0 at stop entry, the enables return exactly 4096 clock edges after the edge that samples the wake request.
- R4: With `fastWakeCfg` = 1 at stop entry, that interval is exactly 32 edges.
- R5: The recovery counter is held at zero for the whole stopped interval. The recovery length therefore does not depend on how long the block stayed stopped.
- R6: While stopped, either `irqReq` or `brkReq` starts recovery.
- R7: A `brkReq` sampled while stopped sets `brkStopFlag` at the next edge. A `brkReq` while running, and an `irqReq` at any time, leave the flag unchanged.
- R8: `brkStopFlag` stays 1 until `statusClr` is sampled high, which clears it. If a set and a clear fall on the same edge, the flag is 1.
- R9: `fastWakeCfg` is sampled only on the stop-entry edge. Changing it while stopped or recovering does not change the current recovery length.
- R10: During recovery, `irqReq`, `brkReq` and `stopReq` are ignored: recovery does not restart, and no new stop is entered.
- R11: `cpuRelease` is high for exactly one cycle. It rises on the same edge at which the clock enables return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Free-running oscillator clock, never gated |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Stop command from the CPU |
| irqReq | input | 1 | Interrupt wake-up request |
| brkReq | input | 1 | Break wake-up request |
| fastWakeCfg | input | 1 | 1 selects the short recovery, 0 the long one |
| statusClr | input | 1 | Software clear of the break-during-stop flag |
| cpuClkEn | output | 1 | Enable for the gated CPU clock |
| perClkEn | output | 1 | Enable for the gated peripheral clock |
| cpuRelease | output | 1 | One-cycle strobe that releases the CPU after recovery |
| brkStopFlag | output | 1 | Sticky flag: a break arrived while stopped |

## Verification
The checker tests these on every cycle:
- that an accepted stop turns off both enables on the next edge;
- that the counter stays at zero while stopped;
- that the counter only ever steps by one during recovery, so recovery cannot restart;
- that the sampled configuration does not move outside running;
- the set, hold and clear rules of the status flag;
- the one-cycle width of the release strobe.

Only the bench scenarios show the exact recovery lengths of 4096 and 32 edges, measured at the ports. The bench scenarios also cover a change of the configuration bit in mid-stop, stop and wake pulses injected during recovery, and the independence of the recovery length from how long the block stayed stopped.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STOPPED = 2'd1,
    ST_RECOVER = 2'd2
  } swcState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic cntClr;      // hold recovery counter at zero
    logic cntInc;      // advance recovery counter
    logic cfgCapture;  // sample the recovery-length select
    logic brkSet;      // latch break-during-stop flag
  } swcStrobe_t;

endpackage

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       irqReq,
  input  logic       brkReq,
  input  logic       termHit,
  output swcState_e  curState,
  output swcStrobe_t strobe,
  output logic       clkGateOn,
  output logic       releasePulse
);

  swcState_e nextState;
  logic      wakeReq;

  assign wakeReq = irqReq | brkReq;

  always_comb begin
    nextState = curState;
    strobe    = '0;
    case (curState)
      ST_RUN: begin
        strobe.cntClr = 1'b1;
        if (stopReq) begin
          strobe.cfgCapture = 1'b1;
          nextState         = ST_STOPPED;
        end
      end
      ST_STOPPED: begin
        strobe.cntClr = 1'b1;
        strobe.brkSet = brkReq;
        if (wakeReq) nextState = ST_RECOVER;
      end
      ST_RECOVER: begin
        // wake and stop requests are deliberately not looked at here
        if (termHit) begin
          strobe.cntClr = 1'b1;
          nextState     = ST_RUN;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState     <= ST_RUN;
      releasePulse <= 1'b0;
    end else begin
      curState     <= nextState;
      releasePulse <= (curState == ST_RECOVER) && termHit;
    end
  end

  assign clkGateOn = (curState == ST_RUN);

endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int LONG_DELAY  = 4096,
  parameter int SHORT_DELAY = 32,
  localparam int CNT_W      = $clog2(LONG_DELAY)
) (
  input  logic             clk,
  input  logic             rstN,
  input  swcStrobe_t       strobe,
  input  logic             fastSel,
  input  logic             statusClr,
  output logic             termHit,
  output logic [CNT_W-1:0] recCnt,
  output logic             cfgFast,
  output logic             brkFlag
);

  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DELAY - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DELAY - 1);

  logic [CNT_W-1:0] lastCount;

  assign lastCount = cfgFast ? SHORT_LAST : LONG_LAST;
  assign termHit   = (recCnt == lastCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (strobe.cntClr) begin
      recCnt <= '0;
    end else if (strobe.cntInc) begin
      recCnt <= recCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgFast <= 1'b0;
    end else if (strobe.cfgCapture) begin
      cfgFast <= fastSel;
    end
  end

  // set has priority over a software clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkFlag <= 1'b0;
    end else if (strobe.brkSet) begin
      brkFlag <= 1'b1;
    end else if (statusClr) begin
      brkFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int LONG_DELAY  = 4096,
  parameter int SHORT_DELAY = 32,
  localparam int CNT_W      = $clog2(LONG_DELAY)
) (
  input  logic oscClk,
  input  logic rstN,
  input  logic stopReq,
  input  logic irqReq,
  input  logic brkReq,
  input  logic fastWakeCfg,
  input  logic statusClr,
  output logic cpuClkEn,
  output logic perClkEn,
  output logic cpuRelease,
  output logic brkStopFlag
);

  swcState_e        curState;
  swcStrobe_t       strobe;
  logic             termHit;
  logic             clkGateOn;
  logic [CNT_W-1:0] recCnt;
  logic             cfgFast;
  logic             stateIsRun;
  logic             stateIsStopped;
  logic             stateIsRecover;

  swc_ctrl u_ctrl (
    .clk          (oscClk),
    .rstN         (rstN),
    .stopReq      (stopReq),
    .irqReq       (irqReq),
    .brkReq       (brkReq),
    .termHit      (termHit),
    .curState     (curState),
    .strobe       (strobe),
    .clkGateOn    (clkGateOn),
    .releasePulse (cpuRelease)
  );

  swc_datapath #(
    .LONG_DELAY  (LONG_DELAY),
    .SHORT_DELAY (SHORT_DELAY)
  ) u_dp (
    .clk       (oscClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fastSel   (fastWakeCfg),
    .statusClr (statusClr),
    .termHit   (termHit),
    .recCnt    (recCnt),
    .cfgFast   (cfgFast),
    .brkFlag   (brkStopFlag)
  );

  assign cpuClkEn       = clkGateOn;
  assign perClkEn       = clkGateOn;
  assign stateIsRun     = (curState == ST_RUN);
  assign stateIsStopped = (curState == ST_STOPPED);
  assign stateIsRecover = (curState == ST_RECOVER);

endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             stopReq,
  input logic             brkReq,
  input logic             statusClr,
  input logic             cpuClkEn,
  input logic             perClkEn,
  input logic             cpuRelease,
  input logic             brkStopFlag,
  input logic             isRun,
  input logic             isStopped,
  input logic             isRecover,
  input logic [CNT_W-1:0] recCnt,
  input logic             cfgFast
);

  p_clk_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isRun && stopReq) |=> (!cpuClkEn && !perClkEn));

  p_cnt_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    isStopped |-> (recCnt == '0));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (isRecover && !cpuRelease && $past(isRecover)) |-> (recCnt == $past(recCnt) + 1'b1));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !isRun |=> (isRun || $stable(cfgFast)));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isStopped && brkReq) |=> brkStopFlag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brkStopFlag && !statusClr) |=> brkStopFlag);

  p_release_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuRelease |=> !cpuRelease);

  p_release_clk_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuRelease |-> (cpuClkEn && perClkEn && !$past(cpuClkEn)));

endmodule

bind stop_wake_ctrl swc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (oscClk),
  .rstN        (rstN),
  .stopReq     (stopReq),
  .brkReq      (brkReq),
  .statusClr   (statusClr),
  .cpuClkEn    (cpuClkEn),
  .perClkEn    (perClkEn),
  .cpuRelease  (cpuRelease),
  .brkStopFlag (brkStopFlag),
  .isRun       (stateIsRun),
  .isStopped   (stateIsStopped),
  .isRecover   (stateIsRecover),
  .recCnt      (recCnt),
  .cfgFast     (cfgFast)
);

// File: tb/sim_stop_wake_ctrl.sv
`timescale 1ns/1ps
module sim_stop_wake_ctrl;

  logic oscClk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, irqReq = 1'b0, brkReq = 1'b0;
  logic fastWakeCfg = 1'b0, statusClr = 1'b0;
  logic cpuClkEn, perClkEn, cpuRelease, brkStopFlag;

  int errCnt = 0;
  int chkCnt = 0;
  int cycles = 0;

  always #4 oscClk = ~oscClk;   // 125 MHz

  stop_wake_ctrl u0 (
    .oscClk      (oscClk),
    .rstN        (rstN),
    .stopReq     (stopReq),
    .irqReq      (irqReq),
    .brkReq      (brkReq),
    .fastWakeCfg (fastWakeCfg),
    .statusClr   (statusClr),
    .cpuClkEn    (cpuClkEn),
    .perClkEn    (perClkEn),
    .cpuRelease  (cpuRelease),
    .brkStopFlag (brkStopFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stop, idle stopped, wake, measure recovery at the ports
  task automatic stopCycle(input logic fast, input logic useBrk, input int idle,
                           input logic pokeRec, input int expDelay, input string req);
    int lows;
    @(negedge oscClk);
    fastWakeCfg = fast;
    stopReq = 1'b1;
    @(negedge oscClk);
    stopReq = 1'b0;
    check({req, "/R2 clocks off"}, {cpuClkEn, perClkEn}, 0);
    fastWakeCfg = ~fast;          // R9: change while stopped
    repeat (idle) @(negedge oscClk);
    check({req, "/R2 still stopped"}, {cpuClkEn, perClkEn}, 0);
    if (useBrk) brkReq = 1'b1; else irqReq = 1'b1;
    @(negedge oscClk);
    brkReq = 1'b0;
    irqReq = 1'b0;
    lows = 0;
    while (!cpuClkEn && lows < 5000) begin
      lows++;
      if (cpuRelease) check({req, "/R11 no early release"}, 1, 0);
      if (pokeRec && lows == 10) begin
        stopReq = 1'b1; irqReq = 1'b1; brkReq = 1'b1;
      end
      if (pokeRec && lows == 11) begin
        stopReq = 1'b0; irqReq = 1'b0; brkReq = 1'b0;
      end
      @(negedge oscClk);
    end
    check({req, " recovery length"}, lows, expDelay);
    check({req, "/R11 release with clocks"}, {cpuRelease, perClkEn}, 2'b11);
    @(negedge oscClk);
    check({req, "/R11 release one cycle"}, cpuRelease, 0);
    check({req, "/R10 running, no new stop"}, cpuClkEn, 1);
    fastWakeCfg = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge oscClk);
    statusClr = 1'b1;
    @(negedge oscClk);
    statusClr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cpuClkEn", cpuClkEn, 1);
    check("R1 perClkEn", perClkEn, 1);
    check("R1 cpuRelease", cpuRelease, 0);
    check("R1 brkStopFlag", brkStopFlag, 0);
  endtask

  task automatic t_short_irq();
    stopCycle(1'b1, 1'b0, 3, 1'b0, 32, "R4 short irq");
    check("R7 irq leaves flag", brkStopFlag, 0);
  endtask

  task automatic t_long_brk();
    stopCycle(1'b0, 1'b1, 2, 1'b0, 4096, "R3 long brk R6");
    check("R7 brk in stop sets flag", brkStopFlag, 1);
    repeat (5) @(negedge oscClk);
    check("R8 flag sticky", brkStopFlag, 1);
    clearFlag();
    check("R8 flag cleared", brkStopFlag, 0);
  endtask

  task automatic t_long_idle();
    stopCycle(1'b1, 1'b0, 300, 1'b0, 32, "R5 long idle R9");
  endtask

  task automatic t_poke_recovery();
    stopCycle(1'b1, 1'b0, 1, 1'b1, 32, "R10 pokes ignored");
    clearFlag();
  endtask

  task automatic t_set_beats_clear();
    @(negedge oscClk);
    stopReq = 1'b1;
    fastWakeCfg = 1'b1;
    @(negedge oscClk);
    stopReq = 1'b0;
    brkReq = 1'b1;
    statusClr = 1'b1;
    @(negedge oscClk);
    brkReq = 1'b0;
    statusClr = 1'b0;
    check("R8 set beats clear", brkStopFlag, 1);
    while (!cpuClkEn) @(negedge oscClk);
    @(negedge oscClk);
    clearFlag();
    check("R8 cleared after", brkStopFlag, 0);
  endtask

  task automatic t_brk_in_run();
    @(negedge oscClk);
    brkReq = 1'b1;
    irqReq = 1'b1;
    @(negedge oscClk);
    brkReq = 1'b0;
    irqReq = 1'b0;
    check("R7 brk in run no flag", brkStopFlag, 0);
    check("R6 wake in run keeps clocks", cpuClkEn, 1);
  endtask

  initial begin
    repeat (3) @(negedge oscClk);
    rstN = 1'b1;
    @(negedge oscClk);
    t_reset();
    t_short_irq();
    t_long_brk();
    t_long_idle();
    t_poke_recovery();
    t_set_beats_clear();
    t_brk_in_run();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  always @(posedge oscClk) begin
    cycles++;
    if (cycles > 100000) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule